// File: doc/BRIEF.md
# Vector Register Chaining Controller

This controller lets a dependent vector instruction read a source register while the instruction producing that register is still writing it. This is register bypassing applied to vectors. For each vector register the controller keeps two pieces of state: a flag that marks a producer in flight, and a count of elements written since that producer started. A consumer asks to read one element at a time. It is granted element i once i is below the written count, so it can start as soon as the first result lands.

A chaining-enable input turns this off. With chaining off, a consumer waits until the producer reports that it has finished. The controller also tracks which registers have an active reader. A producer that tries to retarget such a register is stalled, so results still to be read are not overwritten.

Producers write their elements strictly in order, starting from element 0. A chain such as a load into one register, a multiply that reads it into a second register, and an add that reads the second into a third can therefore run with all three units overlapped.

Top module: `vec_chain_ctrl`

## Requirements
- R1: After reset no register has a producer in flight, so every read request is granted, for any register and any element index.
- R2: An accepted producer start on register r marks r as in flight and sets its written count to zero. From the next cycle, reads of r are refused until elements arrive.
- R3: With chaining enabled, a read of element i of an in-flight register is granted exactly when i is below that register's written count. Each producer write to an in-flight register raises the count by one, and writes arrive in index order starting at 0.
- R4: With chaining disabled, any read of an in-flight register is refused, whatever its written count.
- R5: A producer finish on register r clears the in-flight flag. From the next cycle every element of r is granted.
- R6: A producer start on a register whose reader flag is set raises the stall output in that same cycle. A stalled start changes nothing: the register keeps its previous grant behaviour.
- R7: A consumer start on r sets r's reader flag, and a consumer finish on r clears it. When both arrive for the same register in one cycle, the start wins.
- R8: A write and a read of the same element in the same cycle are not bypassed. The read is refused in that cycle and granted in the next.
- R9: The written count saturates at the register length, 64 elements. Writes beyond that leave every element grantable.
- R10: In a three-instruction chain, the third producer can write its first element while the first producer is still in flight. Each consumer is granted element 0 before its source's producer has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_en | input | 1 | 1 = per-element release, 0 = wait for producer finish |
| prod_start | input | 1 | Producer instruction begins on a destination register |
| prod_start_reg | input | 3 | Destination register of the starting producer |
| prod_start_stall | output | 1 | Start refused because the register has an active reader |
| prod_wr_vld | input | 1 | Producer writes one element |
| prod_wr_reg | input | 3 | Register being written |
| prod_wr_idx | input | 6 | Element index being written |
| prod_done | input | 1 | Producer instruction finished |
| prod_done_reg | input | 3 | Register of the finished producer |
| cons_start | input | 1 | Consumer instruction begins reading a register |
| cons_start_reg | input | 3 | Register the consumer reads |
| cons_done | input | 1 | Consumer instruction finished reading |
| cons_done_reg | input | 3 | Register released by the consumer |
| cons_rd_req | input | 1 | Consumer requests one element |
| cons_rd_reg | input | 3 | Register of the requested element |
| cons_rd_idx | input | 6 | Index of the requested element |
| cons_rd_gnt | output | 1 | Requested element may be read this cycle |

## Verification
Two events can fall in the same cycle: a producer write of element i and a consumer read of that same element. This happens at every step of a chain. The bench provokes it by issuing the write and the read of element k together, and expects a refusal in that cycle and a grant in the next. A reference model built from integers and updated only at the clock edge decides every grant and stall, and it is compared against the design on every cycle. The same comparison judges a stalled producer start that arrives together with a consumer finish on the same register.

// File: rtl/vec_chain_ctrl.sv
module vec_chain_ctrl #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  localparam int RW = $clog2(NREG),
  localparam int EW = $clog2(NELEM),
  localparam int CW = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_en,
  input  logic          prod_start,
  input  logic [RW-1:0] prod_start_reg,
  output logic          prod_start_stall,
  input  logic          prod_wr_vld,
  input  logic [RW-1:0] prod_wr_reg,
  input  logic [EW-1:0] prod_wr_idx,
  input  logic          prod_done,
  input  logic [RW-1:0] prod_done_reg,
  input  logic          cons_start,
  input  logic [RW-1:0] cons_start_reg,
  input  logic          cons_done,
  input  logic [RW-1:0] cons_done_reg,
  input  logic          cons_rd_req,
  input  logic [RW-1:0] cons_rd_reg,
  input  logic [EW-1:0] cons_rd_idx,
  output logic          cons_rd_gnt
);

  logic [NREG-1:0] busy;
  logic [NREG-1:0] rdact;
  logic [CW-1:0]   wcnt [NREG];

  assign prod_start_stall = prod_start && rdact[prod_start_reg];

  assign cons_rd_gnt = cons_rd_req &&
                       (!busy[cons_rd_reg] ||
                        (chain_en && ({1'b0, cons_rd_idx} < wcnt[cons_rd_reg])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      rdact <= '0;
      for (int r = 0; r < NREG; r++) wcnt[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (prod_start && prod_start_reg == RW'(r) && !rdact[r]) begin
          busy[r] <= 1'b1;
          wcnt[r] <= '0;
        end else begin
          if (prod_wr_vld && prod_wr_reg == RW'(r) && busy[r] && wcnt[r] != CW'(NELEM))
            wcnt[r] <= wcnt[r] + 1'b1;
          if (prod_done && prod_done_reg == RW'(r))
            busy[r] <= 1'b0;
        end
        if (cons_start && cons_start_reg == RW'(r))
          rdact[r] <= 1'b1;
        else if (cons_done && cons_done_reg == RW'(r))
          rdact[r] <= 1'b0;
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prod_start && !prod_start_stall |=> busy[$past(prod_start_reg)] && wcnt[$past(prod_start_reg)] == '0); // R2

  AST_WR_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    prod_wr_vld && busy[prod_wr_reg] && wcnt[prod_wr_reg] != CW'(NELEM)
      && !(prod_start && prod_start_reg == prod_wr_reg)
      |-> {1'b0, prod_wr_idx} == wcnt[prod_wr_reg]); // R3

  AST_GNT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cons_rd_gnt && busy[cons_rd_reg] |-> chain_en); // R4

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    prod_done && !(prod_start && !prod_start_stall && prod_start_reg == prod_done_reg)
      |=> !busy[$past(prod_done_reg)]); // R5

  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    prod_start_stall && !(prod_done && prod_done_reg == prod_start_reg)
      |=> busy[$past(prod_start_reg)] == $past(busy[prod_start_reg])); // R6

  AST_READER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cons_start |=> rdact[$past(cons_start_reg)]); // R7

  always @(posedge clk) begin
    if (rst_n) begin
      for (int r = 0; r < NREG; r++)
        AST_CNT_BOUND: assert (wcnt[r] <= CW'(NELEM)); // R9
    end
  end

endmodule

// File: tb/test_vec_chain_ctrl.sv
module test_vec_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int NE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en = 1'b1;
  logic prod_start = 1'b0, prod_wr_vld = 1'b0, prod_done = 1'b0;
  logic cons_start = 1'b0, cons_done = 1'b0, cons_rd_req = 1'b0;
  logic [2:0] prod_start_reg = '0, prod_wr_reg = '0, prod_done_reg = '0;
  logic [2:0] cons_start_reg = '0, cons_done_reg = '0, cons_rd_reg = '0;
  logic [5:0] prod_wr_idx = '0, cons_rd_idx = '0;
  logic prod_start_stall, cons_rd_gnt;

  int checks = 0;
  int errors = 0;
  int m_busy [NR];
  int m_cnt  [NR];
  int m_rd   [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_chain_ctrl i_vec_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
    .prod_start(prod_start), .prod_start_reg(prod_start_reg), .prod_start_stall(prod_start_stall),
    .prod_wr_vld(prod_wr_vld), .prod_wr_reg(prod_wr_reg), .prod_wr_idx(prod_wr_idx),
    .prod_done(prod_done), .prod_done_reg(prod_done_reg),
    .cons_start(cons_start), .cons_start_reg(cons_start_reg),
    .cons_done(cons_done), .cons_done_reg(cons_done_reg),
    .cons_rd_req(cons_rd_req), .cons_rd_reg(cons_rd_reg), .cons_rd_idx(cons_rd_idx),
    .cons_rd_gnt(cons_rd_gnt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    prod_start = 0; prod_wr_vld = 0; prod_done = 0;
    cons_start = 0; cons_done = 0; cons_rd_req = 0;
  endtask

  task automatic tick(input string req);
    logic eg, es;
    #1;
    eg = cons_rd_req && (m_busy[cons_rd_reg] == 0 ||
         (chain_en && int'(cons_rd_idx) < m_cnt[cons_rd_reg]));
    es = prod_start && m_rd[prod_start_reg] != 0;
    check({req, " grant"}, cons_rd_gnt, eg);
    check({req, " stall"}, prod_start_stall, es);
    @(posedge clk);
    if (prod_start && !es) begin
      m_busy[prod_start_reg] = 1; m_cnt[prod_start_reg] = 0;
    end else begin
      if (prod_wr_vld && m_busy[prod_wr_reg] != 0 && m_cnt[prod_wr_reg] < NE)
        m_cnt[prod_wr_reg]++;
      if (prod_done) m_busy[prod_done_reg] = 0;
    end
    if (cons_start) m_rd[cons_start_reg] = 1;
    else if (cons_done) m_rd[cons_done_reg] = 0;
    @(negedge clk);
    clr();
  endtask

  task automatic rd(input int r, input int i);
    cons_rd_req = 1; cons_rd_reg = 3'(r); cons_rd_idx = 6'(i);
  endtask
  task automatic wr(input int r, input int i);
    prod_wr_vld = 1; prod_wr_reg = 3'(r); prod_wr_idx = 6'(i);
  endtask
  task automatic pstart(input int r);
    prod_start = 1; prod_start_reg = 3'(r);
  endtask
  task automatic pdone(input int r);
    prod_done = 1; prod_done_reg = 3'(r);
  endtask
  task automatic cstart(input int r);
    cons_start = 1; cons_start_reg = 3'(r);
  endtask
  task automatic cdone(input int r);
    cons_done = 1; cons_done_reg = 3'(r);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m_busy[r] = 0; m_cnt[r] = 0; m_rd[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state grants anything
    rd(0, 0);  tick("R1");
    rd(7, 63); tick("R1");
    rd(3, 17); tick("R1");

    // R10 chain: v1 load, v3 mul reads v1, v5 add reads v3
    chain_en = 1;
    pstart(1); tick("R2");
    rd(1, 0);  tick("R2");
    cstart(1); pstart(3); tick("R10");
    // R8: write and read of the same element in one cycle
    wr(1, 0); rd(1, 0); tick("R8");
    rd(1, 0); tick("R8");
    rd(1, 1); wr(1, 1); tick("R3");
    rd(1, 1); tick("R3");
    rd(1, 2); tick("R3");
    rd(3, 0); tick("R10");
    wr(3, 0); tick("R10");
    cstart(3); pstart(5); tick("R10");
    rd(3, 0); wr(1, 2); tick("R10");
    wr(5, 0); rd(5, 0); tick("R10");
    rd(5, 0); tick("R10");
    for (int k = 3; k < 10; k++) begin
      wr(1, k); rd(1, k - 1); tick("R3");
    end
    rd(1, 9); tick("R3");
    rd(1, 10); tick("R3");
    pdone(1); cdone(1); tick("R5");
    rd(1, 63); tick("R5");

    // R4 / R5: chaining off
    chain_en = 0;
    pstart(2); tick("R2");
    for (int k = 0; k < 5; k++) begin wr(2, k); rd(2, 0); tick("R4"); end
    rd(2, 0); tick("R4");
    pdone(2); rd(2, 0); tick("R5");
    rd(2, 63); tick("R5");
    rd(3, 0); tick("R4");
    chain_en = 1;

    // R6 / R7: stall on active reader
    cstart(4); tick("R7");
    pstart(4); tick("R6");
    rd(4, 40); tick("R6");
    cdone(4); pstart(4); tick("R6");
    pstart(4); tick("R2");
    rd(4, 0); tick("R2");
    cstart(6); cdone(6); tick("R7");
    pstart(6); tick("R7");
    cdone(6); tick("R7");

    // R9: saturation
    pstart(6); tick("R2");
    for (int k = 0; k < 70; k++) begin wr(6, k % NE); rd(6, 63); tick("R9"); end
    rd(6, 63); tick("R9");
    rd(6, 0); tick("R9");
    pdone(3); pdone(4); tick("R5");
    pdone(5); tick("R5");
    pdone(6); tick("R5");

    // sweep reads over all registers
    for (int k = 0; k < 40; k++) begin rd(k % NR, (k * 13) % NE); tick("R3"); end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule